// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers interrupt events from a CPU's surroundings and turns them into one vector for the core to fetch. There are four kinds of event. Single-cycle pulses come from on-chip peripherals. Asynchronous pins get a synchronizer and an edge detector whose edge is chosen per pin. A key-wakeup detector watches an 8-bit port. A software break pulse comes from the core. Each maskable event sets its own request bit. A request can be serviced only when its enable bit is set and the global disable flag from the core is low.

Seventeen vector slots have a fixed order of precedence. Slot 0 is the reset entry and is always taken first after reset. Slots 1 to 15 are maskable. Slot 16 is the break entry; it has the lowest precedence and ignores both masks. Two of the maskable slots are each shared by two event sources. A source-set register chooses which sources may raise the shared slot, and a read-only discrimination register records which of them did.

The core reads the presented vector pair and pulses an acknowledge. Only the served slot is cleared. The next pending slot then appears on the following cycle. A small register port gives software access to requests, enables, pin polarities, source selection and discrimination.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset is released, `irq_o` is 1 with `slot_o` = 0 and vector pair 0xFFFC/0xFFFD. This holds regardless of `gie_dis_i`, until an acknowledge is given while it is presented.
- R2: While `irq_o` is 1, `vec_lo_o` = 0xFFFC − 2·`slot_o` and `vec_hi_o` = `vec_lo_o` + 1. While `irq_o` is 0, `slot_o`, `vec_lo_o` and `vec_hi_o` are all 0.
- R3: Among the slots that may be presented, the one with the smallest slot number is presented. The break slot (16) therefore yields to every pending maskable slot that may be presented.
- R4: A maskable slot s (1..15) may be presented only when its request bit is 1, enable bit s is 1 and `gie_dis_i` is 0. Otherwise its request stays latched and readable.
- R5: A pulse on `brk_i` latches a break request with no software-visible bit. That request is presented as slot 16 (vector 0xFFDC/0xFFDD) even when `gie_dis_i` is 1.
- R6: `ack_i` high on a clock edge while `irq_o` is 1 clears only the presented slot's request, and the next pending slot is presented from the following cycle. An event arriving for the same slot in the same cycle keeps its request set. `ack_i` has no effect while `irq_o` is 0.
- R7: A one-cycle pulse on `evt_i[i]` sets the request of slot 1, 2, 3, 4, 11, 12, 13 or 14 for i = 0..7 respectively, on the next clock edge.
- R8: Pin `pin_i[p]` (p = 0..4, slots 5, 6, 8, 9, 10) passes through a two-stage synchronizer. Polarity bit p = 1 selects a rising edge and 0 selects a falling edge. The request is set on the third rising clock edge after the pin changes, so `irq_o` can rise no earlier than that edge.
- R9: The key-wakeup event fires on a falling edge of the AND of the synchronized port levels. Only pins whose `key_in_i` bit is 1 count; the others are taken as 1.
- R10: Slot 7 is shared by key wakeup (select/discrimination bit 0) and bus collision (bit 1). Slot 15 is shared by conversion done (bit 2) and timer-1 underflow (bit 3). An event whose select bit is 0 is ignored. A selected event sets its discrimination bit and the slot's request. The slot's two discrimination bits clear whenever that slot's request is cleared.
- R11: Register address 0 holds the requests: bit s is slot s and bit 0 reads 0. Writing a 0 to a bit clears it and writing a 1 leaves it unchanged. Address 1 holds the enables (bit s enables slot s, bit 0 reads 0). Address 2 holds the pin polarities in bits 4:0 and address 3 the source-set bits in 3:0. Address 4 returns the discrimination bits in 3:0 and ignores writes. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Peripheral event pulses for the dedicated slots |
| pin_i | input | 5 | Asynchronous edge-sensitive pins |
| key_port_i | input | 8 | Key-wakeup port levels (asynchronous) |
| key_in_i | input | 8 | Per-pin input configuration of the key port |
| coll_evt_i | input | 1 | Bus-collision event pulse (shared slot 7) |
| conv_evt_i | input | 1 | Conversion-done event pulse (shared slot 15) |
| tmr1_evt_i | input | 1 | Timer-1 underflow pulse (shared slot 15) |
| brk_i | input | 1 | Software break pulse |
| gie_dis_i | input | 1 | Global interrupt-disable flag |
| ack_i | input | 1 | Vector fetch acknowledge |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| irq_o | output | 1 | A vector is presented |
| slot_o | output | 5 | Presented slot number |
| vec_lo_o | output | 16 | Address of the vector's low byte |
| vec_hi_o | output | 16 | Address of the vector's high byte |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, an 8-bit key port and a 16-bit vector base of 0xFFFC. The synchronizer depth fixes the three-edge pin latency, so latency can be checked at an exact cycle. The 8-bit port lets a non-input pin be dropped while a configured pin stays high. With all 17 slots and the break entry present, every precedence relation, the mask paths and both shared slots can be reached in a short run.

// File: rtl/pvi_pkg.sv
package pvi_pkg;
   localparam int NSLOT     = 17;
   localparam int SLOT_W    = 5;
   localparam int NEVT      = 8;
   localparam int NEDGE     = 5;
   localparam int NMASK     = 15;
   localparam int REG_W     = NMASK + 1;
   localparam int SLOT_RST  = 0;
   localparam int SLOT_KEY  = 7;
   localparam int SLOT_CONV = 15;
   localparam int SLOT_BRK  = 16;

   typedef enum logic [2:0] {
      RA_REQ  = 3'd0,
      RA_ENA  = 3'd1,
      RA_POL  = 3'd2,
      RA_SEL  = 3'd3,
      RA_DISC = 3'd4
   } pvi_reg_e;

   // slot served by each dedicated peripheral pulse
   function automatic int evt_slot(input int i);
      case (i)
         0: return 1;
         1: return 2;
         2: return 3;
         3: return 4;
         4: return 11;
         5: return 12;
         6: return 13;
         default: return 14;
      endcase
   endfunction

   // slot served by each edge-sensitive pin
   function automatic int edge_slot(input int i);
      case (i)
         0: return 5;
         1: return 6;
         2: return 8;
         3: return 9;
         default: return 10;
      endcase
   endfunction
endpackage

// File: rtl/pvi_sync_edge.sv
module pvi_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic rise_sel_i,
   output logic hit_o
);
   logic [STAGES-1:0] sync_q;
   logic              prev_q;
   logic              lvl;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= pin_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[STAGES-2:0], pin_i};
         end
      end
   endgenerate

   assign lvl = sync_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign hit_o = rise_sel_i ? (lvl & ~prev_q) : (~lvl & prev_q);
endmodule

// File: rtl/pvi_keywake.sv
module pvi_keywake #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] port_i,
   input  logic [W-1:0] in_mask_i,
   output logic         hit_o
);
   logic [W-1:0] stg_q [STAGES];
   logic         all_hi;
   logic         prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[0] <= '0;
      else        stg_q[0] <= port_i;
   end

   generate
      for (genvar k = 1; k < STAGES; k++) begin : g_stg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[k] <= '0;
            else        stg_q[k] <= stg_q[k-1];
         end
      end
   endgenerate

   // pins not configured as inputs count as high
   assign all_hi = &(stg_q[STAGES-1] | ~in_mask_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= all_hi;
   end

   assign hit_o = prev_q & ~all_hi;
endmodule

// File: rtl/pvi_prio_pick.sv
module pvi_prio_pick #(
   parameter int N  = 17,
   parameter int IW = 5
) (
   input  logic [N-1:0]  pend_i,
   output logic          valid_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      valid_o = |pend_i;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend_i[i]) idx_o = IW'(i);
      end
   end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
   import pvi_pkg::*;
#(
   parameter int          KEY_W       = 8,
   parameter int          SYNC_STAGES = 2,
   parameter int          VEC_W       = 16,
   parameter logic [15:0] VEC_BASE    = 16'hFFFC
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NEVT-1:0]      evt_i,
   input  logic [NEDGE-1:0]     pin_i,
   input  logic [KEY_W-1:0]     key_port_i,
   input  logic [KEY_W-1:0]     key_in_i,
   input  logic                 coll_evt_i,
   input  logic                 conv_evt_i,
   input  logic                 tmr1_evt_i,
   input  logic                 brk_i,
   input  logic                 gie_dis_i,
   input  logic                 ack_i,
   input  logic                 reg_we_i,
   input  logic [2:0]           reg_addr_i,
   input  logic [REG_W-1:0]     reg_wdata_i,
   output logic [REG_W-1:0]     reg_rdata_o,
   output logic                 irq_o,
   output logic [SLOT_W-1:0]    slot_o,
   output logic [VEC_W-1:0]     vec_lo_o,
   output logic [VEC_W-1:0]     vec_hi_o
);
   localparam logic [VEC_W-1:0] BASE = VEC_W'(VEC_BASE);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (KEY_W < 1) begin : g_bad_key
         $error("KEY_W must be at least 1");
      end
      if (VEC_W < 6 || VEC_BASE < 16'd32) begin : g_bad_vec
         $error("vector base too small for 17 slots");
      end
   endgenerate

   logic [NMASK:1]    req_q, ena_q;
   logic [NEDGE-1:0]  pol_q;
   logic [3:0]        sel_q, disc_q, disc_set;
   logic              rst_pend_q, brk_pend_q;
   logic [NEDGE-1:0]  edge_hit;
   logic              key_hit;
   logic [NSLOT-1:0]  set_v, clr_v, pend;
   logic              pick_vld;
   logic [SLOT_W-1:0] pick_idx;
   logic              wr_req, wr_ena, wr_pol, wr_sel;

   // edge-sensitive pins
   generate
      for (genvar p = 0; p < NEDGE; p++) begin : g_pin
         pvi_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (pin_i[p]),
            .rise_sel_i (pol_q[p]),
            .hit_o      (edge_hit[p])
         );
      end
   endgenerate

   pvi_keywake #(.W(KEY_W), .STAGES(SYNC_STAGES)) u_key (
      .clk       (clk),
      .rst_n     (rst_n),
      .port_i    (key_port_i),
      .in_mask_i (key_in_i),
      .hit_o     (key_hit)
   );

   assign wr_req = reg_we_i && (reg_addr_i == RA_REQ);
   assign wr_ena = reg_we_i && (reg_addr_i == RA_ENA);
   assign wr_pol = reg_we_i && (reg_addr_i == RA_POL);
   assign wr_sel = reg_we_i && (reg_addr_i == RA_SEL);

   // shared slots: only selected sources may raise them
   assign disc_set = {tmr1_evt_i & sel_q[3], conv_evt_i & sel_q[2],
                      coll_evt_i & sel_q[1], key_hit    & sel_q[0]};

   always_comb begin
      set_v = '0;
      for (int i = 0; i < NEVT; i++)  set_v[evt_slot(i)]  = evt_i[i];
      for (int i = 0; i < NEDGE; i++) set_v[edge_slot(i)] = edge_hit[i];
      set_v[SLOT_KEY]  = |disc_set[1:0];
      set_v[SLOT_CONV] = |disc_set[3:2];
      set_v[SLOT_BRK]  = brk_i;
   end

   always_comb begin
      clr_v = '0;
      if (ack_i && pick_vld) clr_v[pick_idx] = 1'b1;
      if (wr_req) clr_v[NMASK:1] = clr_v[NMASK:1] | ~reg_wdata_i[NMASK:1];
   end

   assign pend = {brk_pend_q, req_q & ena_q & {NMASK{~gie_dis_i}}, rst_pend_q};

   pvi_prio_pick #(.N(NSLOT), .IW(SLOT_W)) u_pick (
      .pend_i  (pend),
      .valid_o (pick_vld),
      .idx_o   (pick_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q      <= '0;
         ena_q      <= '0;
         pol_q      <= '0;
         sel_q      <= '0;
         disc_q     <= '0;
         rst_pend_q <= 1'b1;
         brk_pend_q <= 1'b0;
      end else begin
         req_q      <= (req_q & ~clr_v[NMASK:1]) | set_v[NMASK:1];
         rst_pend_q <= rst_pend_q & ~clr_v[SLOT_RST];
         brk_pend_q <= (brk_pend_q & ~clr_v[SLOT_BRK]) | set_v[SLOT_BRK];
         disc_q     <= (disc_q & ~{{2{clr_v[SLOT_CONV]}}, {2{clr_v[SLOT_KEY]}}})
                       | disc_set;
         if (wr_ena) ena_q <= reg_wdata_i[NMASK:1];
         if (wr_pol) pol_q <= reg_wdata_i[NEDGE-1:0];
         if (wr_sel) sel_q <= reg_wdata_i[3:0];
      end
   end

   always_comb begin
      case (reg_addr_i)
         RA_REQ:  reg_rdata_o = {req_q, 1'b0};
         RA_ENA:  reg_rdata_o = {ena_q, 1'b0};
         RA_POL:  reg_rdata_o = REG_W'(pol_q);
         RA_SEL:  reg_rdata_o = REG_W'(sel_q);
         RA_DISC: reg_rdata_o = REG_W'(disc_q);
         default: reg_rdata_o = '0;
      endcase
   end

   assign irq_o    = pick_vld;
   assign slot_o   = pick_vld ? pick_idx : '0;
   assign vec_lo_o = pick_vld ? BASE - VEC_W'({pick_idx, 1'b0}) : '0;
   assign vec_hi_o = pick_vld ? BASE - VEC_W'({pick_idx, 1'b0}) + VEC_W'(1) : '0;
endmodule

// File: rtl/pvi_chk.sv
module pvi_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       gie_dis_i,
   input logic       brk_i,
   input logic       ack_i,
   input logic       irq_o,
   input logic [4:0] slot_o
);
   logic first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) first_q <= 1'b1;
      else        first_q <= 1'b0;
   end

   AST_RESET_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      first_q |-> (irq_o && slot_o == 5'd0)); // R1

   AST_RESET_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o && slot_o == 5'd0) |=> !(irq_o && slot_o == 5'd0)); // R6

   AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && gie_dis_i) |-> (slot_o == 5'd0 || slot_o == 5'd16)); // R4

   AST_BREAK_NMI: assert property (@(posedge clk) disable iff (!rst_n)
      brk_i |=> irq_o); // R5

   AST_BREAK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o && slot_o == 5'd16 && !brk_i) |=> !(irq_o && slot_o == 5'd16)); // R6
endmodule

bind prio_vec_intc pvi_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .gie_dis_i (gie_dis_i),
   .brk_i     (brk_i),
   .ack_i     (ack_i),
   .irq_o     (irq_o),
   .slot_o    (slot_o)
);

// File: tb/tb_prio_vec_intc.sv
`timescale 1ns/1ps
module tb_prio_vec_intc;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  evt;
   logic [4:0]  pin;
   logic [7:0]  kport, kin;
   logic        coll, conv, tmr1, brk, dis, ack, we;
   logic [2:0]  addr;
   logic [15:0] wdata;
   logic [15:0] rdata, vlo, vhi;
   logic        irq;
   logic [4:0]  slot;

   int vectors = 0;
   int misses  = 0;
   int cyc     = 0;
   bit run     = 0;
   string phase = "R1";

   always #10 clk = ~clk;

   prio_vec_intc dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .pin_i(pin),
      .key_port_i(kport), .key_in_i(kin), .coll_evt_i(coll),
      .conv_evt_i(conv), .tmr1_evt_i(tmr1), .brk_i(brk),
      .gie_dis_i(dis), .ack_i(ack), .reg_we_i(we), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
      .slot_o(slot), .vec_lo_o(vlo), .vec_hi_o(vhi)
   );

   // ---------------- behavioural reference model ----------------
   bit [15:0] m_req, m_ena;
   bit [4:0]  m_pol, s1, s2, pv;
   bit [3:0]  m_sel, m_disc;
   bit        m_rst, m_brk, kprev;
   bit [7:0]  k1, k2;
   int evt_map[8] = '{1, 2, 3, 4, 11, 12, 13, 14};
   int pin_map[5] = '{5, 6, 8, 9, 10};

   function automatic int pick();
      if (m_rst) return 0;
      if (!dis) for (int s = 1; s < 16; s++) if (m_req[s] && m_ena[s]) return s;
      if (m_brk) return 16;
      return -1;
   endfunction

   function automatic logic [15:0] rd();
      case (addr)
         3'd0: return m_req;
         3'd1: return m_ena;
         3'd2: return {11'd0, m_pol};
         3'd3: return {12'd0, m_sel};
         3'd4: return {12'd0, m_disc};
         default: return 16'd0;
      endcase
   endfunction

   always @(posedge clk) begin : model
      bit [16:0] setv, clrv;
      bit [3:0]  dset;
      bit        kand, kev, ev;
      int        ps;
      if (!rst_n) begin
         m_req = 0; m_ena = 0; m_pol = 0; m_sel = 0; m_disc = 0;
         m_rst = 1; m_brk = 0; s1 = 0; s2 = 0; pv = 0; k1 = 0; k2 = 0; kprev = 0;
      end else begin
         ps = pick(); setv = 0; clrv = 0; dset = 0;
         if (ack && ps >= 0) clrv[ps] = 1;
         if (we && addr == 3'd0) for (int s = 1; s < 16; s++) if (!wdata[s]) clrv[s] = 1;
         for (int i = 0; i < 8; i++) if (evt[i]) setv[evt_map[i]] = 1;
         for (int p = 0; p < 5; p++) begin
            ev = m_pol[p] ? (s2[p] & ~pv[p]) : (~s2[p] & pv[p]);
            if (ev) setv[pin_map[p]] = 1;
         end
         pv = s2; s2 = s1; s1 = pin;
         kand = &(k2 | ~kin); kev = kprev & ~kand; kprev = kand; k2 = k1; k1 = kport;
         if (kev  && m_sel[0]) begin setv[7]  = 1; dset[0] = 1; end
         if (coll && m_sel[1]) begin setv[7]  = 1; dset[1] = 1; end
         if (conv && m_sel[2]) begin setv[15] = 1; dset[2] = 1; end
         if (tmr1 && m_sel[3]) begin setv[15] = 1; dset[3] = 1; end
         if (brk) setv[16] = 1;
         m_disc = (m_disc & ~{clrv[15], clrv[15], clrv[7], clrv[7]}) | dset;
         m_req  = (m_req & ~clrv[15:0]) | setv[15:0];
         m_req[0] = 0;
         m_rst  = m_rst & ~clrv[0];
         m_brk  = (m_brk & ~clrv[16]) | setv[16];
         if (we) case (addr)
            3'd1: m_ena = wdata & 16'hFFFE;
            3'd2: m_pol = wdata[4:0];
            3'd3: m_sel = wdata[3:0];
            default: ;
         endcase
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      int ps;
      logic        e_irq;
      logic [4:0]  e_slot;
      logic [15:0] e_lo, e_hi;
      if (rst_n && run) begin
         ps     = pick();
         e_irq  = (ps >= 0);
         e_slot = e_irq ? 5'(ps) : 5'd0;
         e_lo   = e_irq ? 16'hFFFC - 16'(2 * ps) : 16'd0;
         e_hi   = e_irq ? e_lo + 16'd1 : 16'd0;
         vectors++;
         if (irq !== e_irq || slot !== e_slot || vlo !== e_lo || vhi !== e_hi || rdata !== rd()) begin
            misses++;
            $display("FAIL %s (R2 vector pair): irq/slot/lo/hi/rd got %b/%0d/%h/%h/%h expected %b/%0d/%h/%h/%h",
                     phase, irq, slot, vlo, vhi, rdata, e_irq, e_slot, e_lo, e_hi, rd());
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         misses++;
         $display("FAIL watchdog in %s: got still running expected finished", phase);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic tick();
      @(negedge clk); #2;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      we = 1; addr = a; wdata = d; tick(); we = 0;
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         misses++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   initial begin
      rst_n = 0; evt = 0; pin = 0; kport = 8'hFF; kin = 8'hFF;
      coll = 0; conv = 0; tmr1 = 0; brk = 0; dis = 1; ack = 0;
      we = 0; addr = 0; wdata = 0;
      repeat (3) @(negedge clk);
      #2 rst_n = 1; run = 1;

      // R1: reset entry presented even with disable set
      phase = "R1"; ticks(2);
      chk("R1 slot", slot, 0); chk("R1 lo", vlo, 16'hFFFC); chk("R1 hi", vhi, 16'hFFFD);
      ack = 1; tick(); ack = 0;
      phase = "R2"; tick();
      chk("R2 idle irq", irq, 0); chk("R2 idle lo", vlo, 0);

      // R11: register access
      phase = "R11";
      wr(3'd1, 16'hFFFF); addr = 3'd1; tick(); chk("R11 ena readback", rdata, 16'hFFFE);
      wr(3'd2, 16'h0001); wr(3'd3, 16'h0000);
      wr(3'd4, 16'h000F); addr = 3'd4; tick(); chk("R11 disc write ignored", rdata, 0);

      // R7 + R4: events latch while disable is set
      phase = "R7"; evt = 8'hFF; tick(); evt = 0; tick();
      chk("R4 masked irq", irq, 0);
      addr = 3'd0; tick(); chk("R7 request bits", rdata, 16'h781E);

      // R3 + R6: drain in precedence order
      phase = "R3"; dis = 0; tick(); chk("R3 first slot", slot, 1);
      phase = "R6"; ack = 1; ticks(8); ack = 0; tick();
      chk("R6 drained", irq, 0);
      ack = 1; tick(); ack = 0; chk("R6 stray ack", irq, 0);

      // R4: enable gating
      phase = "R4"; wr(3'd1, 16'hFFFB);
      evt = 8'h03; tick(); evt = 0; tick(); chk("R3 slot1 first", slot, 1);
      ack = 1; tick(); ack = 0; tick();
      chk("R4 disabled slot2", irq, 0); addr = 3'd0; tick(); chk("R4 slot2 latched", rdata, 16'h0004);
      wr(3'd1, 16'hFFFF); tick(); chk("R4 slot2 now", slot, 2);
      ack = 1; tick(); ack = 0;

      // R5: break is non-maskable and lowest
      phase = "R5"; dis = 1; evt = 8'h01; brk = 1; tick(); evt = 0; brk = 0; tick();
      chk("R5 slot", slot, 16); chk("R5 lo", vlo, 16'hFFDC); chk("R5 hi", vhi, 16'hFFDD);
      dis = 0; tick(); chk("R3 break yields", slot, 1);
      ack = 1; tick(); chk("R5 break after", slot, 16); tick(); ack = 0; tick();
      chk("R5 cleared", irq, 0);

      // R6: event in the acknowledge cycle keeps the request
      phase = "R6"; evt = 8'h01; tick(); evt = 0;
      ack = 1; evt = 8'h01; tick(); ack = 0; evt = 0; tick();
      chk("R6 set wins", slot, 1);
      ack = 1; tick(); ack = 0; tick();

      // R8: edge pins, exact latency
      phase = "R8"; pin[0] = 1; ticks(2); chk("R8 not yet", irq, 0);
      tick(); chk("R8 third edge", slot, 5);
      ack = 1; tick(); ack = 0;
      pin[1] = 1; ticks(4); chk("R8 wrong edge", irq, 0);
      pin[1] = 0; ticks(4); chk("R8 falling edge", slot, 6);
      ack = 1; tick(); ack = 0;
      pin[0] = 0; ticks(4); chk("R8 pin0 falling ignored", irq, 0);

      // R9 + R10: key wakeup and shared slots
      phase = "R9"; kin = 8'h0F; kport = 8'h7F; ticks(4); chk("R9 non-input pin", irq, 0);
      phase = "R10"; kport = 8'h7E; ticks(4); chk("R10 unselected key", irq, 0);
      addr = 3'd4; tick(); chk("R10 disc idle", rdata, 0);
      kport = 8'hFF; ticks(3); wr(3'd3, 16'h000F);
      phase = "R9"; kport = 8'hFE; ticks(4); chk("R9 key slot", slot, 7);
      addr = 3'd4; tick(); chk("R10 disc key", rdata, 16'h0001);
      phase = "R10"; coll = 1; tick(); coll = 0; tick(); chk("R10 disc both", rdata, 16'h0003);
      ack = 1; tick(); ack = 0; tick(); chk("R10 disc cleared", rdata, 0);
      wr(3'd3, 16'h000D); coll = 1; tick(); coll = 0; tick(); chk("R10 coll unselected", irq, 0);
      conv = 1; tmr1 = 1; tick(); conv = 0; tmr1 = 0; addr = 3'd4; tick();
      chk("R10 shared slot15", slot, 15); chk("R10 disc conv+tmr", rdata, 16'h000C);
      phase = "R11"; wr(3'd0, 16'h0000); addr = 3'd4; tick();
      chk("R11 write-0 clear", irq, 0); chk("R11 disc follows", rdata, 0);
      ticks(2);

      run = 0;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule